// File: doc/BRIEF.md
# Status Auto-Poll Matcher

This block takes status polling of a serial flash off the CPU. Once started, it asks the command sequencer for a status read, masks the returned word and compares it with a programmed expected value. Between reads it can pause for a programmable number of clock cycles. When the masked bits agree, it raises a sticky match flag and, if enabled, an interrupt.

Depending on a control bit, the block either stops on the first match or keeps polling. In the second case every later match raises the flag again. Software clears the flag through a one-cycle clear strobe. If the expected status never arrives, software ends the loop with an abort strobe.

Serial pin timing and the command encoding belong to the sequencer. This block only drives a request level and consumes a one-cycle response.

Top module: `apm_poller`

## Requirements
- R1: After a synchronous reset, `seq_req`, `busy`, `match_flag` and `irq` are all 0.
- R2: `cmd_start` starts polling only while idle, with `cfg_en` = 1 and `cfg_mode` = 2. The mode codes are 0 indirect write, 1 indirect read, 2 auto-poll and 3 memory-mapped. Any other start leaves `busy` and `seq_req` at 0.
- R3: While polling, `seq_req` stays high until a cycle with `seq_rsp_valid` = 1. A `seq_rsp_valid` pulse while `seq_req` is low is ignored and leaves `match_flag` unchanged.
- R4: An accepted response matches when (status AND mask) equals (expected AND mask). On a match, `match_flag` reads 1 from the following cycle.
- R5: `match_flag` stays set until a cycle with `flag_clr` = 1, and reads 0 after that cycle. If a match is accepted in the same cycle as a clear, the flag stays set.
- R6: `irq` equals `match_flag` AND `cfg_irq_en` in every cycle.
- R7: With `cfg_auto_stop` = 1, the first accepted match returns the block to idle on the next cycle (`busy` = 0, `seq_req` = 0).
- R8: With `cfg_auto_stop` = 0, polling continues after a match, and each later match sets the flag again.
- R9: After an accepted response that does not stop polling, `seq_req` stays low for exactly N cycles before the next request, where N is the captured interval. N = 0 keeps `seq_req` high without a gap.
- R10: `cmd_abort` while busy returns the block to idle on the next cycle. A response in the same cycle is discarded, so `match_flag` is not set by it.
- R11: Dropping `cfg_en`, or moving `cfg_mode` away from 2, while busy ends polling like an abort.
- R12: Mask, expected value and interval are captured at start. Changing them while polling has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Block enable |
| cfg_mode | input | 2 | Functional mode code; 2 selects auto-poll |
| cfg_auto_stop | input | 1 | Stop polling on first match |
| cfg_irq_en | input | 1 | Match interrupt enable |
| cfg_mask | input | W | Bits of the status word that take part in the compare |
| cfg_match | input | W | Expected status value |
| cfg_interval | input | IW | Idle cycles between status reads |
| cmd_start | input | 1 | Start polling (one-cycle strobe) |
| cmd_abort | input | 1 | Abort polling (one-cycle strobe) |
| flag_clr | input | 1 | Clear match flag (one-cycle strobe) |
| seq_req | output | 1 | Status-read request to the sequencer |
| seq_rsp_valid | input | 1 | Sequencer returns a status word |
| seq_rsp_status | input | W | Returned status word |
| busy | output | 1 | Polling in progress |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |

## Verification
The compare is tried with status words that differ from the expected value only in unmasked bits, or only in masked bits, so that a compare which ignores the mask is separated from a correct one. Mask and expected value are changed in the middle of a poll, which exposes a design that compares against live settings instead of captured ones. Stop-on-match is run with a non-zero gap, and continuous polling with a zero gap, so the counting of idle cycles is checked apart from the stop decision. A response is made to coincide with a flag clear and with an abort, which pins down which of the two wins in each case.

// File: rtl/apm_pkg.sv
package apm_pkg;

    typedef enum logic [1:0] {
        FM_IND_WR   = 2'd0,
        FM_IND_RD   = 2'd1,
        FM_AUTOPOLL = 2'd2,
        FM_MEMMAP   = 2'd3
    } fmode_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_REQ  = 2'd1,
        PS_GAP  = 2'd2
    } poll_state_e;

    function automatic logic is_autopoll(input logic [1:0] mode);
        return mode == FM_AUTOPOLL;
    endfunction

endpackage

// File: rtl/apm_compare.sv
module apm_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] expect_val,
    output logic         hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (status ^ expect_val) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/apm_gap_timer.sv
module apm_gap_timer #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == IW'(1));
endmodule

// File: rtl/apm_flag.sv
module apm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/apm_poller.sv
module apm_poller
    import apm_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_auto_stop,
    input  logic          cfg_irq_en,
    input  logic [W-1:0]  cfg_mask,
    input  logic [W-1:0]  cfg_match,
    input  logic [IW-1:0] cfg_interval,
    input  logic          cmd_start,
    input  logic          cmd_abort,
    input  logic          flag_clr,
    output logic          seq_req,
    input  logic          seq_rsp_valid,
    input  logic [W-1:0]  seq_rsp_status,
    output logic          busy,
    output logic          match_flag,
    output logic          irq
);
    poll_state_e   state;
    logic [W-1:0]  cap_mask;
    logic [W-1:0]  cap_match;
    logic [IW-1:0] cap_ivl;
    logic          run_ok;
    logic          stop_now;
    logic          accept;
    logic          hit;
    logic          finish;
    logic          gap_load;
    logic          gap_last;
    logic          flag_set;

    assign run_ok   = cfg_en && is_autopoll(cfg_mode);
    assign stop_now = cmd_abort || !run_ok;
    assign accept   = (state == PS_REQ) && seq_rsp_valid && !stop_now;
    assign finish   = accept && hit && cfg_auto_stop;
    assign gap_load = accept && !finish && (cap_ivl != '0);
    assign flag_set = accept && hit;

    apm_compare #(.W(W)) u_cmp (
        .status     (seq_rsp_status),
        .mask       (cap_mask),
        .expect_val (cap_match),
        .hit        (hit)
    );

    apm_gap_timer #(.IW(IW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (cap_ivl),
        .run      (state == PS_GAP),
        .last     (gap_last)
    );

    apm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (flag_set),
        .clr    (flag_clr),
        .irq_en (cfg_irq_en),
        .flag   (match_flag),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_IDLE;
            cap_mask  <= '0;
            cap_match <= '0;
            cap_ivl   <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    if (cmd_start && run_ok) begin
                        state     <= PS_REQ;
                        cap_mask  <= cfg_mask;
                        cap_match <= cfg_match;
                        cap_ivl   <= cfg_interval;
                    end
                end
                PS_REQ: begin
                    if (stop_now || finish) begin
                        state <= PS_IDLE;
                    end else if (gap_load) begin
                        state <= PS_GAP;
                    end
                end
                PS_GAP: begin
                    if (stop_now) begin
                        state <= PS_IDLE;
                    end else if (gap_last) begin
                        state <= PS_REQ;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign seq_req = (state == PS_REQ);
    assign busy    = (state != PS_IDLE);

endmodule

// File: rtl/apm_poller_chk.sv
module apm_poller_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_en,
    input logic [1:0]   cfg_mode,
    input logic         cfg_auto_stop,
    input logic         cmd_start,
    input logic         cmd_abort,
    input logic         flag_clr,
    input logic         seq_rsp_valid,
    input logic [W-1:0] seq_rsp_status,
    input logic [W-1:0] cap_mask,
    input logic [W-1:0] cap_match,
    input logic         seq_req,
    input logic         busy,
    input logic         match_flag
);
    logic go;
    logic ok_hit;

    assign go     = cfg_en && (cfg_mode == 2'd2);
    assign ok_hit = (((seq_rsp_status & cap_mask) == (cap_match & cap_mask)));

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !seq_req);

    a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(cmd_start && go)) |=> !busy);

    a_r3_req_holds: assert property (@(posedge clk) disable iff (rst)
        (seq_req && !seq_rsp_valid && !cmd_abort && go) |=> seq_req);

    a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_rsp_valid && !cmd_abort && go && ok_hit) |=> match_flag);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_clr) |=> match_flag);

    a_r7_auto_stop: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_rsp_valid && !cmd_abort && go && ok_hit && cfg_auto_stop) |=> !busy);

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_abort && !flag_clr) |=> (!busy && (match_flag == $past(match_flag))));

    a_r11_disable_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && !go) |=> !busy);
endmodule

bind apm_poller apm_poller_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_en         (cfg_en),
    .cfg_mode       (cfg_mode),
    .cfg_auto_stop  (cfg_auto_stop),
    .cmd_start      (cmd_start),
    .cmd_abort      (cmd_abort),
    .flag_clr       (flag_clr),
    .seq_rsp_valid  (seq_rsp_valid),
    .seq_rsp_status (seq_rsp_status),
    .cap_mask       (cap_mask),
    .cap_match      (cap_match),
    .seq_req        (seq_req),
    .busy           (busy),
    .match_flag     (match_flag)
);

// File: tb/apm_poller_tb.sv
`timescale 1ns/1ps
module apm_poller_tb;
    localparam int W  = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_auto_stop = 1'b0;
    logic          cfg_irq_en = 1'b0;
    logic [W-1:0]  cfg_mask = '0;
    logic [W-1:0]  cfg_match = '0;
    logic [IW-1:0] cfg_interval = '0;
    logic          cmd_start = 1'b0;
    logic          cmd_abort = 1'b0;
    logic          flag_clr = 1'b0;
    logic          seq_rsp_valid = 1'b0;
    logic [W-1:0]  seq_rsp_status = '0;
    logic          seq_req, busy, match_flag, irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    int m_busy = 0, m_gap = 0, m_cnt = 0, m_flag = 0;
    int c_mask = 0, c_match = 0, c_ivl = 0;

    always #5 clk = ~clk;

    apm_poller #(.W(W), .IW(IW)) u_dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int set_f, go, hit;
        if (rst) begin
            m_busy = 0; m_gap = 0; m_cnt = 0; m_flag = 0;
            c_mask = 0; c_match = 0; c_ivl = 0;
            return;
        end
        set_f = 0;
        go = (cfg_en == 1'b1) && (cfg_mode == 2'd2);
        if (m_busy == 0) begin
            if (cmd_start && go) begin
                m_busy = 1; m_gap = 0;
                c_mask = int'(cfg_mask); c_match = int'(cfg_match); c_ivl = int'(cfg_interval);
            end
        end else if (cmd_abort || !go) begin
            m_busy = 0;
        end else if (m_gap == 0) begin
            if (seq_rsp_valid) begin
                hit = ((int'(seq_rsp_status) & c_mask) == (c_match & c_mask));
                if (hit) set_f = 1;
                if (hit && cfg_auto_stop) m_busy = 0;
                else if (c_ivl != 0) begin m_gap = 1; m_cnt = c_ivl; end
            end
        end else begin
            if (m_cnt == 1) m_gap = 0;
            m_cnt = m_cnt - 1;
        end
        if (set_f) m_flag = 1;
        else if (flag_clr) m_flag = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        check({cur_req, " req"},  int'(seq_req), (m_busy != 0 && m_gap == 0) ? 1 : 0);
        check({cur_req, " busy"}, int'(busy), m_busy);
        check({cur_req, " flag"}, int'(match_flag), m_flag);
        check("R6 irq", int'(irq), (m_flag != 0 && cfg_irq_en) ? 1 : 0);
    endtask

    task automatic start_poll(input logic [W-1:0] mk, input logic [W-1:0] mt,
                              input int ivl, input logic stop);
        cfg_en = 1'b1; cfg_mode = 2'd2; cfg_mask = mk; cfg_match = mt;
        cfg_interval = IW'(ivl); cfg_auto_stop = stop;
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 300 && !seq_req; i++) tick();
    endtask

    task automatic respond(input logic [W-1:0] s);
        wait_req();
        seq_rsp_valid = 1'b1; seq_rsp_status = s;
        tick();
        seq_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int low;
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        // R1 reset state
        check("R1 req", int'(seq_req), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 flag", int'(match_flag), 0);

        // R2 start rejected in wrong mode or while disabled
        cur_req = "R2";
        cfg_en = 1'b1; cfg_mode = 2'd1; cmd_start = 1'b1; tick();
        cfg_mode = 2'd3; tick();
        cfg_mode = 2'd2; cfg_en = 1'b0; tick(); cmd_start = 1'b0; tick();
        check("R2 busy after rejected starts", int'(busy), 0);

        // R3 stray response while idle is ignored
        cur_req = "R3";
        seq_rsp_valid = 1'b1; seq_rsp_status = '0; tick(); seq_rsp_valid = 1'b0; tick();
        check("R3 flag after stray response", int'(match_flag), 0);

        // R4 R7 R9: wait for bit0 to clear, interval 3, stop on match
        cur_req = "R4";
        start_poll(16'h0001, 16'h0000, 3, 1'b1);
        repeat (4) tick();
        check("R3 req held while waiting", int'(seq_req), 1);
        respond(16'h0003);
        cur_req = "R9";
        low = 0;
        while (!seq_req && low < 50) begin low++; tick(); end
        check("R9 gap length", low, 3);
        cur_req = "R4";
        respond(16'h0083);
        check("R4 no match on masked bit", int'(match_flag), 0);
        respond(16'h0002);
        check("R4 match sets flag", int'(match_flag), 1);
        check("R7 stopped after match", int'(busy), 0);

        // R6 interrupt follows flag and enable
        cur_req = "R6";
        check("R6 irq masked", int'(irq), 0);
        cfg_irq_en = 1'b1; #1;
        check("R6 irq enabled", int'(irq), 1);
        tick();

        // R5 clear
        cur_req = "R5";
        repeat (3) tick();
        check("R5 flag sticky", int'(match_flag), 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        check("R5 flag cleared", int'(match_flag), 0);

        // R8 continuous polling, no gap
        cur_req = "R8";
        start_poll(16'h00FF, 16'h0042, 0, 1'b0);
        respond(16'h1142);
        check("R8 match flag", int'(match_flag), 1);
        check("R8 still busy", int'(busy), 1);
        check("R9 zero gap keeps req", int'(seq_req), 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        respond(16'h0043);
        check("R8 no match", int'(match_flag), 0);
        respond(16'hAB42);
        check("R8 flag set again", int'(match_flag), 1);
        // R5 set wins over clear
        cur_req = "R5";
        wait_req();
        flag_clr = 1'b1; seq_rsp_valid = 1'b1; seq_rsp_status = 16'h0042;
        tick(); flag_clr = 1'b0; seq_rsp_valid = 1'b0;
        check("R5 set wins over clear", int'(match_flag), 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;

        // R10 abort with simultaneous matching response
        cur_req = "R10";
        wait_req();
        cmd_abort = 1'b1; seq_rsp_valid = 1'b1; seq_rsp_status = 16'h0042;
        tick(); cmd_abort = 1'b0; seq_rsp_valid = 1'b0;
        check("R10 idle after abort", int'(busy), 0);
        check("R10 response discarded", int'(match_flag), 0);

        // R11 disable ends polling
        cur_req = "R11";
        start_poll(16'h0001, 16'h0001, 2, 1'b1);
        tick();
        cfg_en = 1'b0; tick();
        check("R11 idle after disable", int'(busy), 0);
        cfg_en = 1'b1;
        start_poll(16'h0001, 16'h0001, 2, 1'b1);
        cfg_mode = 2'd0; tick(); cfg_mode = 2'd2;
        check("R11 idle after mode change", int'(busy), 0);

        // R12 captured settings
        cur_req = "R12";
        start_poll(16'h00F0, 16'h0050, 1, 1'b1);
        cfg_mask = 16'h0000; cfg_match = 16'h0060; cfg_interval = 8'd9;
        respond(16'h0060);
        check("R12 live mask ignored", int'(match_flag), 0);
        low = 0;
        while (!seq_req && low < 50) begin low++; tick(); end
        check("R12 captured interval", low, 1);
        respond(16'h0057);
        check("R12 captured match", int'(match_flag), 1);
        check("R12 stopped", int'(busy), 0);
        repeat (3) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule